// File: doc/BRIEF.md
# Three-Level Nested Interrupt Arbiter

The block sits between a set of interrupt source flags and a processor core. It selects at most one vector to offer to the core. Sixteen source flags, each with its own enable, are merged onto ten vectors. Each vector has a one-bit level setting that gives it one of three priorities: top, high or low. A vector is offered only when its level is strictly above the level of the interrupt the core is currently servicing. Among the vectors that can be offered, the highest level wins, and a tie goes to the vector with the smallest address.

The core takes an offered interrupt with `ack`. The block records the level of that interrupt as in service. At the end of the handler the core pulses `reti`, which retires the innermost level and lets requests at lower levels through again. Source flags belong to the surrounding logic, which keeps them set until software clears them. The block only reads them. Fetching the handler and saving processor context are done outside the block.

Top module: `irq_nest_ctrl`

## Requirements
- R1: A vector requests when at least one of its sources has both flag and enable set. The source-to-vector map is: s0→v0, s1→v1, s2/s3/s4→v2, s5/s6→v3, s7/s8→v4, s9/s10→v5, s11→v6, s12→v7, s13/s14/s15→v8.
- R2: Bit v of `vec_lvl` picks the level of vector v. For vectors 0 and 1, 1 means top and 0 means low. For vectors 2 to 9, 1 means high and 0 means low. The order is top > high > low.
- R3: If requesting vectors sit at different levels, the vector at the highest level is offered.
- R4: If several requesting vectors share the winning level, the one with the smallest address is offered.
- R5: A vector whose level is equal to or below the innermost in-service level is not offered. A vector at a strictly higher level is offered, which lets handlers nest.
- R6: Vector i has address 03h + 8h·i, so the addresses run 03h, 0Bh, … 4Bh.
- R7: `irq` and `vec_addr` are registered. They reflect inputs and in-service state from the previous clock edge.
- R8: An `ack` while `irq` is high marks the offered level as in service. `irq` is low in the next cycle, and `vec_addr` keeps the acknowledged address.
- R9: A `reti` removes only the highest level that is in service. Any lower levels stay in service.
- R10: An `ack` while `irq` is low has no effect.
- R11: After synchronous reset, `irq` is 0, `vec_addr` is 0 and no level is in service.
- R12: Vector 9 has no sources, so address 4Bh is never offered.
- R13: While `irq` is low, `vec_addr` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_flag | input | 16 | Source request flags |
| src_en | input | 16 | Per-source enables |
| vec_lvl | input | 10 | Per-vector level select |
| ack | input | 1 | Core accepts the offered interrupt |
| reti | input | 1 | Core returns from the innermost handler |
| irq | output | 1 | An interrupt is being offered |
| vec_addr | output | 8 | Address of the offered vector |

## Verification
The bench focuses on four corner cases.
- Ties at one level. A design that scanned the vectors in the wrong direction would offer 13h instead of 03h.
- Equal-level blocking during nesting. A design using ≥ in place of > would re-offer a high vector inside a high handler.
- Partial unwinding with `reti`. A design that cleared every in-service bit would let a high request through while a high handler is still active.
- An `ack` arriving while nothing is offered. A design that accepted it would silently block a later low request.

Shared vectors, masked sources and the top level of the first two vectors are also driven directly. Long randomized runs are then compared every cycle against a behavioural model.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

  localparam int unsigned LVL_W = 2;

  typedef enum logic [LVL_W-1:0] {
    LVL_NONE = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_TOP  = 2'd3
  } lvl_e;

  localparam int unsigned NO_VECTOR = 32'hFFFF_FFFF;

  // fixed wiring of sources onto vectors; the last vector has no source
  function automatic int unsigned src_to_vec(input int unsigned s);
    case (s)
      0:          return 0;
      1:          return 1;
      2, 3, 4:    return 2;
      5, 6:       return 3;
      7, 8:       return 4;
      9, 10:      return 5;
      11:         return 6;
      12:         return 7;
      13, 14, 15: return 8;
      default:    return NO_VECTOR;
    endcase
  endfunction

endpackage

// File: rtl/irq_vec_merge.sv
module irq_vec_merge
  import irq_nest_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned NUM_VEC = 10
) (
  input  logic [NUM_SRC-1:0] src_flag,
  input  logic [NUM_SRC-1:0] src_en,
  output logic [NUM_VEC-1:0] vec_req
);

  logic [NUM_SRC-1:0] live;
  assign live = src_flag & src_en;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    always_comb begin
      vec_req[v] = 1'b0;
      for (int s = 0; s < NUM_SRC; s++) begin
        if (src_to_vec(s) == v) vec_req[v] = vec_req[v] | live[s];
      end
    end
  end

endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
  import irq_nest_pkg::*;
#(
  parameter int unsigned NUM_VEC = 10,
  parameter int unsigned NUM_TOP = 2
) (
  input  logic [NUM_VEC-1:0]            lvl_sel,
  output logic [NUM_VEC-1:0][LVL_W-1:0] vec_level
);

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_map
    if (v < NUM_TOP) begin : g_top_capable
      assign vec_level[v] = lvl_sel[v] ? LVL_TOP : LVL_LOW;
    end else begin : g_high_capable
      assign vec_level[v] = lvl_sel[v] ? LVL_HIGH : LVL_LOW;
    end
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_nest_pkg::*;
#(
  parameter int unsigned NUM_VEC  = 10,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned VEC_BASE = 3,
  parameter int unsigned VEC_STEP = 8
) (
  input  logic [NUM_VEC-1:0]            vec_req,
  input  logic [NUM_VEC-1:0][LVL_W-1:0] vec_level,
  input  logic [LVL_W-1:0]              cur_lvl,
  output logic                          win_valid,
  output logic [LVL_W-1:0]              win_lvl,
  output logic [ADDR_W-1:0]             win_addr
);

  localparam int unsigned IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic [IDX_W-1:0] best_idx;
  logic [LVL_W-1:0] best_lvl;

  // strict comparison keeps the first (lowest address) vector on a tie
  always_comb begin
    best_idx = '0;
    best_lvl = LVL_NONE;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (vec_req[v] && (vec_level[v] > cur_lvl) && (vec_level[v] > best_lvl)) begin
        best_idx = IDX_W'(v);
        best_lvl = vec_level[v];
      end
    end
  end

  assign win_valid = (best_lvl != LVL_NONE);
  assign win_lvl   = best_lvl;
  assign win_addr  = ADDR_W'(VEC_BASE) + ADDR_W'(best_idx) * ADDR_W'(VEC_STEP);

endmodule

// File: rtl/irq_inservice.sv
module irq_inservice
  import irq_nest_pkg::*;
#(
  parameter int unsigned NUM_LVL = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_en,
  input  logic [LVL_W-1:0]   set_lvl,
  input  logic               clr_en,
  output logic [NUM_LVL-1:0] ins,
  output logic [LVL_W-1:0]   cur_lvl
);

  logic [NUM_LVL-1:0] ins_q;
  logic [NUM_LVL-1:0] top_mask;
  logic [NUM_LVL-1:0] set_mask;

  // top_mask marks the innermost (highest) level that is in service
  always_comb begin
    top_mask = '0;
    cur_lvl  = LVL_NONE;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (ins_q[l]) begin
        top_mask = '0;
        top_mask[l] = 1'b1;
        cur_lvl = LVL_W'(l + 1);
      end
    end
  end

  always_comb begin
    set_mask = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (set_en && (set_lvl == LVL_W'(l + 1))) set_mask[l] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ins_q <= '0;
    end else begin
      ins_q <= (ins_q & ~(clr_en ? top_mask : '0)) | set_mask;
    end
  end

  assign ins = ins_q;

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 16,
  parameter int unsigned NUM_VEC  = 10,
  parameter int unsigned NUM_TOP  = 2,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned VEC_BASE = 3,
  parameter int unsigned VEC_STEP = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_flag,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [NUM_VEC-1:0] vec_lvl,
  input  logic               ack,
  input  logic               reti,
  output logic               irq,
  output logic [ADDR_W-1:0]  vec_addr
);

  localparam int unsigned NUM_LVL = 3;

  logic [NUM_VEC-1:0]            vec_req;
  logic [NUM_VEC-1:0][LVL_W-1:0] vec_level;
  logic [LVL_W-1:0]              cur_lvl;
  logic [NUM_LVL-1:0]            ins_q;
  logic                          win_valid;
  logic [LVL_W-1:0]              win_lvl;
  logic [ADDR_W-1:0]             win_addr;

  logic                          irq_q;
  logic [ADDR_W-1:0]             addr_q;
  logic [LVL_W-1:0]              plvl_q;
  logic                          ack_ok;

  irq_vec_merge #(.NUM_SRC(NUM_SRC), .NUM_VEC(NUM_VEC)) u_merge (
    .src_flag (src_flag),
    .src_en   (src_en),
    .vec_req  (vec_req)
  );

  irq_level_map #(.NUM_VEC(NUM_VEC), .NUM_TOP(NUM_TOP)) u_lvl (
    .lvl_sel   (vec_lvl),
    .vec_level (vec_level)
  );

  irq_arbiter #(
    .NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_arb (
    .vec_req   (vec_req),
    .vec_level (vec_level),
    .cur_lvl   (cur_lvl),
    .win_valid (win_valid),
    .win_lvl   (win_lvl),
    .win_addr  (win_addr)
  );

  assign ack_ok = ack & irq_q;

  irq_inservice #(.NUM_LVL(NUM_LVL)) u_ins (
    .clk     (clk),
    .rst     (rst),
    .set_en  (ack_ok),
    .set_lvl (plvl_q),
    .clr_en  (reti),
    .ins     (ins_q),
    .cur_lvl (cur_lvl)
  );

  // offer register: frozen address on acceptance, refreshed only on a winner
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      addr_q <= '0;
      plvl_q <= LVL_NONE;
    end else if (ack_ok) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= win_valid;
      if (win_valid) begin
        addr_q <= win_addr;
        plvl_q <= win_lvl;
      end
    end
  end

  assign irq      = irq_q;
  assign vec_addr = addr_q;

endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_VEC  = 10,
  parameter int unsigned VEC_BASE = 3,
  parameter int unsigned VEC_STEP = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input logic [ADDR_W-1:0] vec_addr,
  input logic              ack,
  input logic              reti,
  input logic [2:0]        ins,
  input logic [1:0]        cur_lvl,
  input logic [1:0]        pend_lvl
);

  localparam int unsigned LAST_ADDR = VEC_BASE + (NUM_VEC - 1) * VEC_STEP;

  // R5
  offer_above_current_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (pend_lvl > cur_lvl));

  // R6
  addr_on_grid_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((int'(vec_addr) >= int'(VEC_BASE)) && (int'(vec_addr) <= int'(LAST_ADDR)) &&
             (((int'(vec_addr) - int'(VEC_BASE)) % int'(VEC_STEP)) == 0)));

  // R8
  ack_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && irq) |=> !irq);

  // R8
  ack_holds_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && irq) |=> $stable(vec_addr));

  // R9
  reti_pops_one_chk: assert property (@(posedge clk) disable iff (rst)
    (reti && !ack && (ins != 3'b000)) |=> ($countones(ins) == $countones($past(ins)) - 1));

  // R10
  stray_ack_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !irq && !reti) |=> $stable(ins));

  // R13
  idle_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq && $past(!irq) && !$past(rst)) |-> $stable(vec_addr));

endmodule

bind irq_nest_ctrl irq_nest_chk #(
  .ADDR_W(ADDR_W), .NUM_VEC(NUM_VEC), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq      (irq),
  .vec_addr (vec_addr),
  .ack      (ack),
  .reti     (reti),
  .ins      (ins_q),
  .cur_lvl  (cur_lvl),
  .pend_lvl (plvl_q)
);

// File: tb/sim_irq_nest_ctrl.sv
module sim_irq_nest_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] src_flag = '0;
  logic [15:0] src_en = '0;
  logic [9:0]  vec_lvl = '0;
  logic        ack = 1'b0;
  logic        reti = 1'b0;
  logic        irq;
  logic [7:0]  vec_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_nest_ctrl u0 (
    .clk(clk), .rst(rst), .src_flag(src_flag), .src_en(src_en), .vec_lvl(vec_lvl),
    .ack(ack), .reti(reti), .irq(irq), .vec_addr(vec_addr)
  );

  // ---------------- behavioural reference ----------------
  int   owner [16] = '{0, 1, 2, 2, 2, 3, 3, 4, 4, 5, 5, 6, 7, 8, 8, 8};
  bit   busy [4];          // busy[1]=low, [2]=high, [3]=top
  bit   m_irq;
  int   m_addr;
  int   m_lvl;

  always @(posedge clk) begin
    int cur, best_l, best_v, lv;
    bit any, took;
    if (rst) begin
      m_irq = 0; m_addr = 0; m_lvl = 0;
      foreach (busy[i]) busy[i] = 0;
    end else begin
      cur = 0;
      for (int l = 1; l <= 3; l++) if (busy[l]) cur = l;
      best_l = 0; best_v = 0;
      for (int v = 0; v < 10; v++) begin
        any = 0;
        for (int s = 0; s < 16; s++) if (owner[s] == v && src_flag[s] && src_en[s]) any = 1;
        lv = vec_lvl[v] ? ((v < 2) ? 3 : 2) : 1;
        if (any && lv > cur && lv > best_l) begin best_l = lv; best_v = v; end
      end
      took = ack && m_irq;
      if (reti && cur > 0) busy[cur] = 0;
      if (took) begin
        busy[m_lvl] = 1;
        m_irq = 0;
      end else begin
        m_irq = (best_l > 0);
        if (best_l > 0) begin m_addr = 3 + 8 * best_v; m_lvl = best_l; end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (irq !== m_irq || vec_addr !== 8'(m_addr)) begin
        fails++;
        $display("FAIL R7 cycle compare: irq=%0b addr=%02h expected irq=%0b addr=%02h",
                 irq, vec_addr, m_irq, m_addr);
      end
      if (irq === 1'b1 && vec_addr === 8'h4B) begin
        fails++;
        $display("FAIL R12 empty vector offered: addr=%02h expected not 4B", vec_addr);
      end
    end
  end

  task automatic expect_out(string tag, bit ei, logic [7:0] ea);
    checks++;
    if (irq !== ei || (ei && vec_addr !== ea)) begin
      fails++;
      $display("FAIL %s: irq=%0b addr=%02h expected irq=%0b addr=%02h", tag, irq, vec_addr, ei, ea);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1; cycles(1); ack = 0;
  endtask

  task automatic pulse_reti();
    reti = 1; cycles(1); reti = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    cycles(WATCHDOG);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    cycles(3);
    expect_out("R11 reset state", 0, 8'h00);
    checks++;
    if (vec_addr !== 8'h00) begin fails++; $display("FAIL R11 addr=%02h expected 00", vec_addr); end
    rst = 0;
    src_en = '1;

    // R1 R6: shared source s3 reaches vector 2 at 13h
    src_flag[3] = 1; cycles(2);
    expect_out("R1 R6 shared vector", 1, 8'h13);

    // R4: tie at low level goes to smallest address
    src_flag[0] = 1; cycles(2);
    expect_out("R4 tie lowest address", 1, 8'h03);

    // R3: high beats low
    vec_lvl[5] = 1; src_flag[10] = 1; cycles(2);
    expect_out("R3 higher level wins", 1, 8'h2B);

    // R8: acceptance drops irq, keeps address
    pulse_ack();
    expect_out("R8 irq after ack", 0, 8'h2B);
    checks++;
    if (vec_addr !== 8'h2B) begin fails++; $display("FAIL R8 addr=%02h expected 2B", vec_addr); end
    // R5: equal and lower levels blocked
    cycles(2);
    expect_out("R5 equal level blocked", 0, 8'h2B);

    // R5 nesting: top level interrupts the high handler
    vec_lvl[1] = 1; src_flag[1] = 1; cycles(2);
    expect_out("R5 nested top", 1, 8'h0B);
    pulse_ack();
    src_flag[1] = 0;

    // R9: one reti leaves high in service
    pulse_reti(); cycles(2);
    expect_out("R9 partial unwind", 0, 8'h0B);
    pulse_reti(); cycles(2);
    expect_out("R9 full unwind", 1, 8'h2B);

    // R13 and R10: stray ack while idle
    src_flag = '0; cycles(2);
    expect_out("R13 idle", 0, 8'h2B);
    checks++;
    if (vec_addr !== 8'h2B) begin fails++; $display("FAIL R13 addr=%02h expected 2B", vec_addr); end
    pulse_ack();
    src_flag[2] = 1; cycles(2);
    expect_out("R10 stray ack ignored", 1, 8'h13);

    // R1: enable masks a flag; another source of the same vector still counts
    src_en[2] = 0; cycles(2);
    expect_out("R1 masked source", 0, 8'h13);
    src_flag[4] = 1; cycles(2);
    expect_out("R1 merged source", 1, 8'h13);

    // R2: vector 0 at top beats a high vector
    src_flag = '0; src_en = '1; vec_lvl = '0;
    vec_lvl[0] = 1; vec_lvl[5] = 1; src_flag[0] = 1; src_flag[9] = 1; cycles(2);
    expect_out("R2 top select", 1, 8'h03);
    vec_lvl[0] = 0; cycles(2);
    expect_out("R2 low select", 1, 8'h2B);

    // R12: every source active, all low, 4Bh never appears
    vec_lvl = '0; src_flag = '1; cycles(2);
    expect_out("R12 all sources", 1, 8'h03);

    // randomized run compared every cycle
    rst = 1; cycles(2); rst = 0;
    for (int i = 0; i < 4000; i++) begin
      src_flag = 16'($urandom) & 16'($urandom);
      src_en   = 16'($urandom) | 16'($urandom);
      if (($urandom % 8) == 0) vec_lvl = 10'($urandom);
      ack  = (($urandom % 3) == 0);
      reti = (($urandom % 7) == 0);
      cycles(1);
    end
    ack = 0; reti = 0;
    cycles(2);
    finish_run();
  end

endmodule